// File: doc/BRIEF.md
# I2C Challenge-Response Key Target

This block is an I2C target that serves as a hardware unlock key. A bus controller on the host side addresses it at a fixed 7-bit address. It reaches a small set of byte registers through a register pointer. The host writes two 4-bit operands packed into one challenge byte. It then reads back a result register that holds the bitwise XOR of the two operands. The result bits are returned only after the host has set the matching bits of a direction register to "output". Until then the result reads as zero.

Both bus lines are sampled with the system clock after a synchronizer chain. START and STOP are recognised as SDA edges while SCL is high. The target never drives SCL. On SDA it only pulls low or releases, through a single pull-enable output.

A register write is a two-byte transaction: a pointer byte, then a value byte. A register read is done in two steps. First a one-byte write sets the pointer. Then a separate read transaction returns the addressed register.

Top module: `i2c_xor_key`

## Requirements
- R1: After a START, an address byte whose upper seven bits equal 0x20 is acknowledged: the target holds SDA low during the ninth SCL high period. This holds for both the write (bit 0 = 0) and the read (bit 0 = 1) direction.
- R2: An address byte with any other 7-bit address is not acknowledged. SDA stays released through that byte and all later bytes up to the next START, and the bytes written in that transaction change no register.
- R3: In a write transaction, the first byte after the address loads the register pointer and each later byte is stored in the register the pointer selects. Every written byte is acknowledged. A register changes only when a byte is written to it.
- R4: The direction register at pointer 0x01 resets to 0xFF (all bits input) and reads back the last value written.
- R5: The result register at pointer 0x12 returns, in bits 3:0, the XOR of challenge bits 7:4 and bits 3:0. Bits 7:4 read as 0. Each result bit also reads 0 while the matching direction bit is 1, so after reset it reads 0x00.
- R6: The challenge register at pointer 0x13 resets to 0x00 and reads back the last value written.
- R7: The register pointer is kept across STOP and START. A read transaction returns the register it selects. When the controller acknowledges a read byte, the next byte returns the same register again.
- R8: The target changes its SDA drive only after SCL has been seen low. It releases SDA after a read byte the controller does not acknowledge, and it releases SDA after a STOP.
- R9: A pointer other than 0x01, 0x12 or 0x13 reads as 0x00, and writing to it changes no register.
- R10: During and right after reset, the SDA pull output is inactive (0), and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it (open drain) |

## Verification
The bench builds the block with its defaults: target address 0x20, 8-bit registers (4-bit operands) and a two-stage synchronizer. With a bus quarter-period of five system clocks, the synchronizer delay plus the register stage stays well inside one SCL low phase. This lets the bench sample the acknowledge and every data bit in the middle of the SCL high phase. Random challenge bytes and random direction masks (fully output, fully input and mixed) cover the masking of every result bit. Directed cases cover a foreign address, an unmapped pointer and the pointer values at reset.

// File: rtl/i2c_key_pkg.sv
package i2c_key_pkg;

  // Bus engine phases
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } key_state_e;

  // Register pointer values the host relies on
  localparam logic [7:0] PTR_DIR    = 8'h01;
  localparam logic [7:0] PTR_RESULT = 8'h12;
  localparam logic [7:0] PTR_CHAL   = 8'h13;

endpackage

// File: rtl/i2c_key_sync.sv
module i2c_key_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] prev_o
);

  // one synchronizer chain plus an edge-history flop per bus line
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic              hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= '1;
        hist_q <= 1'b1;
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], raw_i[g]};
        hist_q <= pipe_q[STAGES-1];
      end
    end

    assign sync_o[g] = pipe_q[STAGES-1];
    assign prev_o[g] = hist_q;
  end

endmodule

// File: rtl/i2c_key_regs.sv
module i2c_key_regs
  import i2c_key_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] ptr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dir,
  output logic [DATA_W-1:0] chal
);

  localparam int NIB_W = DATA_W / 2;

  logic              dir_en;
  logic              chal_en;
  logic [DATA_W-1:0] xor_res;

  assign dir_en  = wr_en && (ptr == DATA_W'(PTR_DIR));
  assign chal_en = wr_en && (ptr == DATA_W'(PTR_CHAL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir  <= '1;
      chal <= '0;
    end else begin
      if (dir_en)  dir  <= wr_data;
      if (chal_en) chal <= wr_data;
    end
  end

  // response: operand XOR, bits gated by the port direction
  assign xor_res = {{(DATA_W-NIB_W){1'b0}},
                    chal[DATA_W-1:NIB_W] ^ chal[NIB_W-1:0]};

  always_comb begin
    if (ptr == DATA_W'(PTR_DIR))         rd_data = dir;
    else if (ptr == DATA_W'(PTR_CHAL))   rd_data = chal;
    else if (ptr == DATA_W'(PTR_RESULT)) rd_data = xor_res & ~dir;
    else                                 rd_data = '0;
  end

endmodule

// File: rtl/i2c_key_engine.sv
module i2c_key_engine
  import i2c_key_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h20,
  parameter int         DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_p,
  input  logic              sda_p,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ptr,
  output logic              sda_pull
);

  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int ADDR_W = 7;

  key_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              first_q, first_d;
  logic              mack_q, mack_d;
  logic              pull_q, pull_d;

  logic start_ev, stop_ev, scl_rise, scl_fall, byte_end;

  assign start_ev = scl_s && scl_p && sda_p && !sda_s;
  assign stop_ev  = scl_s && scl_p && !sda_p && sda_s;
  assign scl_rise = scl_s && !scl_p;
  assign scl_fall = !scl_s && scl_p;
  assign byte_end = scl_fall && (cnt_q == CNT_W'(DATA_W));

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    first_d = first_q;
    mack_d  = mack_q;
    pull_d  = pull_q;
    wr_en   = 1'b0;
    if (start_ev) begin
      st_d   = ST_ADDR;
      cnt_d  = '0;
      pull_d = 1'b0;
    end else if (stop_ev) begin
      st_d   = ST_IDLE;
      pull_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end
          if (byte_end) begin
            cnt_d = '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[ADDR_W:1] == DEV_ADDR) begin
                rw_d   = sh_q[0];
                pull_d = 1'b1;
                st_d   = ST_ADDR_ACK;
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              pull_d  = 1'b1;
              st_d    = ST_WR_ACK;
              first_d = 1'b0;
              if (first_q) ptr_d = sh_q;
              else         wr_en = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              sh_d   = rd_data;
              pull_d = ~rd_data[DATA_W-1];
              st_d   = ST_RD;
            end else begin
              pull_d  = 1'b0;
              first_d = 1'b1;
              st_d    = ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            st_d   = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) cnt_d = cnt_q + 1'b1;
          if (byte_end) begin
            pull_d = 1'b0;
            cnt_d  = '0;
            st_d   = ST_RD_ACK;
          end else if (scl_fall) begin
            sh_d   = {sh_q[DATA_W-2:0], 1'b1};
            pull_d = ~sh_q[DATA_W-2];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack_d = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              sh_d   = rd_data;
              pull_d = ~rd_data[DATA_W-1];
              st_d   = ST_RD;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      mack_q  <= mack_d;
      pull_q  <= pull_d;
    end
  end

  assign wr_data  = sh_q;
  assign ptr      = ptr_q;
  assign sda_pull = pull_q;

endmodule

// File: rtl/i2c_xor_key.sv
module i2c_xor_key #(
  parameter logic [6:0] DEV_ADDR    = 7'h20,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);

  logic [1:0]        line_s, line_p;
  logic              scl_s, sda_s, scl_p, sda_p;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, ptr, dir, chal, rd_data;

  i2c_key_sync #(.STAGES(SYNC_STAGES), .LINES(2)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sda_i, scl_i}),
    .sync_o (line_s),
    .prev_o (line_p)
  );

  assign scl_s = line_s[0];
  assign sda_s = line_s[1];
  assign scl_p = line_p[0];
  assign sda_p = line_p[1];

  i2c_key_engine #(.DEV_ADDR(DEV_ADDR), .DATA_W(DATA_W)) eng_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_p    (scl_p),
    .sda_p    (sda_p),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ptr      (ptr),
    .sda_pull (sda_pull_o)
  );

  i2c_key_regs #(.DATA_W(DATA_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .ptr     (ptr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .dir     (dir),
    .chal    (chal)
  );

endmodule

// File: rtl/i2c_xor_key_chk.sv
module i2c_xor_key_chk
  import i2c_key_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_s,
  input logic              sda_pull_o,
  input logic              wr_en,
  input logic [DATA_W-1:0] ptr,
  input logic [DATA_W-1:0] dir,
  input logic [DATA_W-1:0] chal,
  input logic [DATA_W-1:0] rd_data
);

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !$past(scl_s)); // R8

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && sda_s && !$past(sda_s)) |=> !sda_pull_o); // R8

  AST_RESULT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == DATA_W'(PTR_RESULT) && dir == '1) |-> rd_data == '0); // R5

  AST_CHAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(chal)); // R3

endmodule

bind i2c_xor_key i2c_xor_key_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .sda_s      (sda_s),
  .sda_pull_o (sda_pull_o),
  .wr_en      (wr_en),
  .ptr        (ptr),
  .dir        (dir),
  .chal       (chal),
  .rd_data    (rd_data)
);

// File: tb/i2c_xor_key_tb_top.sv
module i2c_xor_key_tb_top;

  localparam int Q = 5;  // system clocks per quarter bus period

  logic clk, rst_n, scl_m, sda_m;
  logic sda_pull;
  logic sda_line;
  int   n_tests, n_fail;
  logic [7:0] dir_m, chal_m;

  assign sda_line = sda_m & ~sda_pull;

  i2c_xor_key dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input logic [7:0] p);
    case (p)
      8'h01:   return dir_m;
      8'h13:   return chal_m;
      8'h12:   return {4'h0, chal_m[7:4] ^ chal_m[3:0]} & ~dir_m;
      default: return 8'h00;
    endcase
  endfunction

  task automatic qwait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait;
    scl_m = 1'b1; qwait; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qwait;
    scl_m = 1'b1; qwait;
    b = sda_line; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl_m = 1'b1; qwait;
    sda_m = 1'b0; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qwait;
    scl_m = 1'b1; qwait;
    sda_m = 1'b1; qwait; qwait;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(~mack);
  endtask

  task automatic wr_xfer(input logic [6:0] a, input logic [7:0] p, input logic [7:0] v,
                         input bit with_val, output logic [2:0] acks);
    bus_start;
    send_byte({a, 1'b0}, acks[2]);
    send_byte(p, acks[1]);
    acks[0] = 1'b0;
    if (with_val) send_byte(v, acks[0]);
    bus_stop;
  endtask

  task automatic rd_xfer(output logic [7:0] d0, output logic [7:0] d1, output logic aack);
    bus_start;
    send_byte({7'h20, 1'b1}, aack);
    recv_byte(d0, 1'b1);
    recv_byte(d1, 1'b0);
    bus_stop;
  endtask

  task automatic set_reg(input logic [7:0] p, input logic [7:0] v, input string req);
    logic [2:0] acks;
    wr_xfer(7'h20, p, v, 1'b1, acks);
    check({req, " write acks"}, {5'h0, acks}, 8'h07);
    if (p == 8'h01) dir_m = v;
    if (p == 8'h13) chal_m = v;
  endtask

  task automatic read_reg(input logic [7:0] p, input string req);
    logic [2:0] acks;
    logic [7:0] d0, d1;
    logic       aack;
    wr_xfer(7'h20, p, 8'h00, 1'b0, acks);
    check({req, " pointer acks"}, {5'h0, acks}, 8'h06);
    rd_xfer(d0, d1, aack);
    check("R1 read address ack", {7'h0, aack}, 8'h01);
    check({req, " read byte"}, d0, exp_reg(p));
    check("R7 repeated byte", d1, exp_reg(p));
    check("R8 released after stop", {7'h0, sda_pull}, 8'h00);
  endtask

  initial begin
    logic [7:0] d0, d1, r, p;
    logic       aack;
    logic [2:0] acks;
    int unsigned seed_dummy;
    n_tests = 0; n_fail = 0;
    dir_m = 8'hFF; chal_m = 8'h00;
    seed_dummy = $urandom(32'd2024);
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 pull inactive in reset", {7'h0, sda_pull}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 pull inactive after reset", {7'h0, sda_pull}, 8'h00);

    // R10/R9: pointer 0x00 at reset reads zero
    rd_xfer(d0, d1, aack);
    check("R1 address ack", {7'h0, aack}, 8'h01);
    check("R10 reset pointer read", d0, 8'h00);

    read_reg(8'h01, "R4 dir reset");
    read_reg(8'h12, "R5 result at reset");
    read_reg(8'h13, "R6 challenge reset");

    // R2: foreign address ignored
    wr_xfer(7'h21, 8'h13, 8'h77, 1'b1, acks);
    check("R2 foreign address nack", {5'h0, acks}, 8'h00);
    read_reg(8'h13, "R2 challenge untouched");

    // directed example
    set_reg(8'h01, 8'h00, "R3");
    set_reg(8'h13, 8'h5A, "R3");
    read_reg(8'h12, "R5 result 5^A");
    read_reg(8'h13, "R6 challenge readback");
    read_reg(8'h01, "R4 dir readback");

    // R9: unmapped pointer
    set_reg(8'h40, 8'hAA, "R9");
    read_reg(8'h40, "R9 unmapped read");
    read_reg(8'h13, "R9 challenge unchanged");

    for (int k = 0; k < 24; k++) begin
      r = 8'($urandom);
      case (k % 3)
        0: set_reg(8'h01, 8'h00, "R3");
        1: set_reg(8'h01, 8'hFF, "R3");
        default: set_reg(8'h01, r, "R3");
      endcase
      set_reg(8'h13, 8'($urandom), "R3");
      read_reg(8'h12, "R5 random result");
      if (k % 6 == 0) read_reg(8'h13, "R6 random challenge");
    end

    p = 8'($urandom) | 8'h80;
    read_reg(p, "R9 random unmapped");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule